// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block is a passive observer on the byte stream of an SPI command set for a small Ethernet controller. It does no serial shifting. A byte assembler upstream gives it one MOSI/MISO byte pair per valid strobe, together with the raw chip-select level. A frame begins when chip select falls and ends when it rises. The first byte of a frame is the header. Its three upper bits give the command class and its five lower bits give the register address.

At the end of each frame the monitor applies the rules for that command: the expected length, the fixed header of the buffer commands, and the extra dummy byte that a read of a MAC/MII register needs. It raises a separate flag for each rule that fails. It also keeps a shadow copy of the two register-bank select bits, which live at address 0x1F of the device. The shadow follows register writes, bit-set, bit-clear and reset commands, and each bank bit has its own "known" flag.

A small external lookup tells the monitor whether the current bank and address name a MAC/MII register. The monitor presents the bank and address on `lk_bank` and `lk_addr`, and the lookup answers on `mac_reg`. All results appear with a one-cycle `done` pulse and stay unchanged until the next `done`.

Top module: `spi_cmd_mon`

## Requirements
- R1: While and after reset, `done` is 0, all result outputs and warning flags are 0, and both bank bits are unknown (`res_bank_known`=0).
- R2: One clock after the clock edge that samples `cs_n` high at the end of a frame with at least one byte, `done` is high for exactly one cycle. At that point `res_cmd` holds byte0[7:5] and `res_addr` holds byte0[4:0]. The opcode codes are: 0 control read, 1 buffer read, 2 control write, 3 buffer write, 4 bit set, 5 bit clear, 6 undefined, 7 soft reset. The results do not change while `done` is low.
- R3: A frame that carries no valid byte while `cs_n` is low produces no `done` pulse and leaves every result output unchanged.
- R4: Opcode 6 raises `warn_opcode` with every other warning clear, and it leaves the bank shadow unchanged.
- R5: Opcode 1 with a header other than 0x3A, or opcode 3 with a header other than 0x7A, raises `warn_header`. Buffer commands of any length raise no length warning.
- R6: The allowed frame lengths are: 2 or 3 bytes for opcode 0; exactly 2 bytes for opcodes 2, 4 and 5; exactly 1 byte for opcode 7. Any other length raises `warn_length` and leaves the bank shadow unchanged.
- R7: A valid control write to address 0x1F loads the bank from byte1[1:0] and makes both bank bits known.
- R8: A valid bit set (or bit clear) to address 0x1F sets (or clears) each bank bit i for which byte1[i] is 1, and marks only those bits as known. `res_bank_known` is 1 only when both bits are known.
- R9: A valid soft reset (opcode 7, 1 byte) sets the bank to 0 and makes both bits known.
- R10: A register-access command (opcode 0, 2, 4 or 5) of valid length raises `warn_bank` when the bank is not fully known before the frame. `res_bank` and `res_bank_known` report the bank state as it was before the frame.
- R11: A control read of valid length, made while the bank is known, raises `warn_dummy` in two cases: `mac_reg` is 1 and the length is not 3, or `mac_reg` is 0 and the length is not 2. `mac_reg` is sampled at frame end for `lk_bank`/`lk_addr`.
- R12: The data byte `res_data` is chosen by opcode:
  - opcode 0: MISO byte2 when the length is 3, otherwise MISO byte1;
  - opcode 1: MISO byte1;
  - opcodes 2 to 5: MOSI byte1;
  - opcodes 6 and 7: 0.
  A byte that was not received reads as 0.
- R13: `res_len` holds the number of bytes in the frame and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select level, low inside a frame |
| byte_vld | input | 1 | Strobe for one byte pair |
| mosi_byte | input | 8 | Byte sent by the master |
| miso_byte | input | 8 | Byte returned by the device |
| mac_reg | input | 1 | Lookup answer: `lk_bank`/`lk_addr` name a MAC/MII register |
| lk_bank | output | 2 | Current shadow bank, for the lookup |
| lk_addr | output | 5 | Address of the frame in progress, for the lookup |
| done | output | 1 | One-cycle pulse when a frame's results are presented |
| res_cmd | output | 3 | Opcode of the frame |
| res_addr | output | 5 | Register address of the frame |
| res_bank | output | 2 | Bank in effect for the frame |
| res_bank_known | output | 1 | Both bank bits were known for the frame |
| res_data | output | 8 | Captured data byte |
| res_len | output | 8 | Frame length in bytes, saturating |
| warn_opcode | output | 1 | Undefined opcode |
| warn_header | output | 1 | Bad buffer-command header |
| warn_length | output | 1 | Bad frame length |
| warn_bank | output | 1 | Register access with the bank unknown |
| warn_dummy | output | 1 | Control-read length does not match the register class |

## Verification
The bench first drives a bit set and then a bit clear, each touching only one bank bit. A design that marked the whole bank known on the first of these would drop the bank warning on the read that follows. A control write to 0x1F of the wrong length must leave the bank alone; a design that updated it anyway would report the wrong bank on later reads. Control reads of MAC/MII and non-MAC/MII registers, each with and without the dummy byte, catch a design that swaps the rule or picks the wrong MISO byte. An empty frame and a 300-byte buffer write catch a spurious `done` pulse and a length counter that wraps instead of saturating.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;
    localparam int ADDR_W = BYTE_W - OP_W;
    localparam int BANK_W = 2;
    localparam int LEN_W  = 8;

    localparam logic [LEN_W-1:0]  LEN_MAX    = '1;
    localparam logic [ADDR_W-1:0] BANK_REG   = 5'h1F;
    localparam logic [BYTE_W-1:0] RD_BUF_HDR = 8'h3A;
    localparam logic [BYTE_W-1:0] WR_BUF_HDR = 8'h7A;

    typedef enum logic [OP_W-1:0] {
        OP_RD_CTL   = 3'd0,
        OP_RD_BUF   = 3'd1,
        OP_WR_CTL   = 3'd2,
        OP_WR_BUF   = 3'd3,
        OP_BIT_SET  = 3'd4,
        OP_BIT_CLR  = 3'd5,
        OP_UNDEF    = 3'd6,
        OP_SOFT_RST = 3'd7
    } op_e;

    typedef struct packed {
        logic opc;
        logic hdr;
        logic len;
        logic bank;
        logic dummy;
    } warn_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hdr;
        logic [BYTE_W-1:0] mosi1;
        logic [BYTE_W-1:0] miso1;
        logic [BYTE_W-1:0] miso2;
        logic [LEN_W-1:0]  len;
    } frame_t;

    typedef struct packed {
        logic [OP_W-1:0]   cmd;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              known;
        logic [BYTE_W-1:0] data;
        logic [LEN_W-1:0]  len;
        warn_t             warn;
    } result_t;

    function automatic op_e hdr_op(input logic [BYTE_W-1:0] hdr);
        return op_e'(hdr[BYTE_W-1 -: OP_W]);
    endfunction

    function automatic logic is_reg_access(input op_e op);
        return (op == OP_RD_CTL) || (op == OP_WR_CTL) ||
               (op == OP_BIT_SET) || (op == OP_BIT_CLR);
    endfunction

    function automatic logic length_ok(input op_e op, input logic [LEN_W-1:0] n);
        case (op)
            OP_RD_CTL:                        return (n == LEN_W'(2)) || (n == LEN_W'(3));
            OP_WR_CTL, OP_BIT_SET, OP_BIT_CLR: return n == LEN_W'(2);
            OP_SOFT_RST:                      return n == LEN_W'(1);
            OP_RD_BUF, OP_WR_BUF:             return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/smon_frame_capture.sv
module smon_frame_capture
    import spi_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] mosi_byte,
    input  logic [BYTE_W-1:0] miso_byte,
    output frame_t            frm,
    output logic              frame_end
);

    logic       cs_q;
    frame_t     frm_q;
    frame_t     frm_d;
    logic       start;
    logic       take;
    logic [LEN_W-1:0] idx;

    assign start = !cs_n && cs_q;
    assign take  = !cs_n && byte_vld;
    assign idx   = start ? '0 : frm_q.len;

    always_comb begin
        frm_d = frm_q;
        if (start) begin
            frm_d = '0;
        end
        if (take) begin
            if (idx == LEN_W'(0)) begin
                frm_d.hdr = mosi_byte;
            end else if (idx == LEN_W'(1)) begin
                frm_d.mosi1 = mosi_byte;
                frm_d.miso1 = miso_byte;
            end else if (idx == LEN_W'(2)) begin
                frm_d.miso2 = miso_byte;
            end
            if (frm_d.len != LEN_MAX) begin
                frm_d.len = frm_d.len + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            frm_q <= '0;
        end else begin
            cs_q  <= cs_n;
            frm_q <= frm_d;
        end
    end

    assign frm       = frm_q;
    assign frame_end = cs_n && !cs_q && (frm_q.len != '0);

    AST_LEN_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (frm_q.len == LEN_MAX && take && !start) |=> (frm_q.len == LEN_MAX)); // R13

endmodule

// File: rtl/smon_frame_check.sv
module smon_frame_check
    import spi_mon_pkg::*;
(
    input  frame_t            frm,
    input  logic              bank_known,
    input  logic              mac_reg,
    output warn_t             warn,
    output logic              len_ok,
    output logic [BYTE_W-1:0] data
);

    op_e op;
    assign op = hdr_op(frm.hdr);

    always_comb begin
        warn   = '0;
        len_ok = length_ok(op, frm.len);
        if (op == OP_UNDEF) begin
            warn.opc = 1'b1;
            len_ok   = 1'b0;
        end else begin
            warn.len = !len_ok;
            if (op == OP_RD_BUF) begin
                warn.hdr = (frm.hdr != RD_BUF_HDR);
            end
            if (op == OP_WR_BUF) begin
                warn.hdr = (frm.hdr != WR_BUF_HDR);
            end
            if (is_reg_access(op) && len_ok) begin
                warn.bank = !bank_known;
                if (op == OP_RD_CTL && bank_known) begin
                    warn.dummy = mac_reg ? (frm.len != LEN_W'(3))
                                         : (frm.len != LEN_W'(2));
                end
            end
        end
    end

    always_comb begin
        case (op)
            OP_RD_CTL:  data = (frm.len == LEN_W'(3)) ? frm.miso2 : frm.miso1;
            OP_RD_BUF:  data = frm.miso1;
            OP_WR_CTL,
            OP_WR_BUF,
            OP_BIT_SET,
            OP_BIT_CLR: data = frm.mosi1;
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/smon_bank_track.sv
module smon_bank_track
    import spi_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] mask,
    input  logic              len_ok,
    output logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] known
);

    logic [BANK_W-1:0] bank_q, bank_d;
    logic [BANK_W-1:0] known_q, known_d;
    logic              upd;
    logic              hit;

    assign upd = fire && len_ok;
    assign hit = (addr == BANK_REG);

    always_comb begin
        bank_d  = bank_q;
        known_d = known_q;
        if (upd) begin
            case (op)
                OP_WR_CTL: begin
                    if (hit) begin
                        bank_d  = mask;
                        known_d = '1;
                    end
                end
                OP_BIT_SET, OP_BIT_CLR: begin
                    if (hit) begin
                        for (int i = 0; i < BANK_W; i++) begin
                            if (mask[i]) begin
                                bank_d[i]  = (op == OP_BIT_SET);
                                known_d[i] = 1'b1;
                            end
                        end
                    end
                end
                OP_SOFT_RST: begin
                    bank_d  = '0;
                    known_d = '1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            known_q <= '0;
        end else begin
            bank_q  <= bank_d;
            known_q <= known_d;
        end
    end

    assign bank  = bank_q;
    assign known = known_q;

    AST_SOFT_RST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_SOFT_RST) |=> (bank_q == '0 && known_q == '1)); // R9
    AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable({bank_q, known_q})); // R6
    AST_KNOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (known_q == '1) |=> (known_q == '1)); // R8

endmodule

// File: rtl/spi_cmd_mon.sv
module spi_cmd_mon
    import spi_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] mosi_byte,
    input  logic [BYTE_W-1:0] miso_byte,
    input  logic              mac_reg,
    output logic [BANK_W-1:0] lk_bank,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              done,
    output logic [OP_W-1:0]   res_cmd,
    output logic [ADDR_W-1:0] res_addr,
    output logic [BANK_W-1:0] res_bank,
    output logic              res_bank_known,
    output logic [BYTE_W-1:0] res_data,
    output logic [LEN_W-1:0]  res_len,
    output logic              warn_opcode,
    output logic              warn_header,
    output logic              warn_length,
    output logic              warn_bank,
    output logic              warn_dummy
);

    frame_t            frm;
    logic              frame_end;
    warn_t             warn;
    logic              len_ok;
    logic [BYTE_W-1:0] data;
    logic [BANK_W-1:0] bank;
    logic [BANK_W-1:0] known;
    logic              bank_known;
    result_t           res_q;
    logic              done_q;

    assign bank_known = &known;

    smon_frame_capture i_capture (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .byte_vld  (byte_vld),
        .mosi_byte (mosi_byte),
        .miso_byte (miso_byte),
        .frm       (frm),
        .frame_end (frame_end)
    );

    smon_frame_check i_check (
        .frm        (frm),
        .bank_known (bank_known),
        .mac_reg    (mac_reg),
        .warn       (warn),
        .len_ok     (len_ok),
        .data       (data)
    );

    smon_bank_track i_bank (
        .clk    (clk),
        .rst    (rst),
        .fire   (frame_end),
        .op     (hdr_op(frm.hdr)),
        .addr   (frm.hdr[ADDR_W-1:0]),
        .mask   (frm.mosi1[BANK_W-1:0]),
        .len_ok (len_ok),
        .bank   (bank),
        .known  (known)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (frame_end) begin
                res_q.cmd   <= frm.hdr[BYTE_W-1 -: OP_W];
                res_q.addr  <= frm.hdr[ADDR_W-1:0];
                res_q.bank  <= bank;
                res_q.known <= bank_known;
                res_q.data  <= data;
                res_q.len   <= frm.len;
                res_q.warn  <= warn;
            end
        end
    end

    assign lk_bank        = bank;
    assign lk_addr        = frm.hdr[ADDR_W-1:0];
    assign done           = done_q;
    assign res_cmd        = res_q.cmd;
    assign res_addr       = res_q.addr;
    assign res_bank       = res_q.bank;
    assign res_bank_known = res_q.known;
    assign res_data       = res_q.data;
    assign res_len        = res_q.len;
    assign warn_opcode    = res_q.warn.opc;
    assign warn_header    = res_q.warn.hdr;
    assign warn_length    = res_q.warn.len;
    assign warn_bank      = res_q.warn.bank;
    assign warn_dummy     = res_q.warn.dummy;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(res_q)); // R2
    AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_len != '0)); // R3
    AST_OPCODE_ALONE: assert property (@(posedge clk) disable iff (rst)
        (done && warn_opcode) |-> !(warn_header || warn_length || warn_bank || warn_dummy)); // R4

endmodule

// File: tb/test_spi_cmd_mon.sv
module test_spi_cmd_mon;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] mosi_byte = '0;
    logic [7:0] miso_byte = '0;
    logic       mac_reg;
    logic [1:0] lk_bank;
    logic [4:0] lk_addr;
    logic       done;
    logic [2:0] res_cmd;
    logic [4:0] res_addr;
    logic [1:0] res_bank;
    logic       res_bank_known;
    logic [7:0] res_data;
    logic [7:0] res_len;
    logic       warn_opcode, warn_header, warn_length, warn_bank, warn_dummy;

    int total = 0;
    int bad   = 0;
    int npush = 0;
    int ndone = 0;

    logic [31:0] q_vec[$];
    string       q_req[$];

    logic [1:0] mb = 2'b00;
    logic [1:0] mk = 2'b00;

    always #10 clk = ~clk;

    function automatic logic mac_lookup(input logic [1:0] b, input logic [4:0] a);
        return (b == 2'd2) && (a < 5'h1A);
    endfunction

    assign mac_reg = mac_lookup(lk_bank, lk_addr);

    spi_cmd_mon i_spi_cmd_mon (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld),
        .mosi_byte(mosi_byte), .miso_byte(miso_byte), .mac_reg(mac_reg),
        .lk_bank(lk_bank), .lk_addr(lk_addr), .done(done),
        .res_cmd(res_cmd), .res_addr(res_addr), .res_bank(res_bank),
        .res_bank_known(res_bank_known), .res_data(res_data), .res_len(res_len),
        .warn_opcode(warn_opcode), .warn_header(warn_header),
        .warn_length(warn_length), .warn_bank(warn_bank), .warn_dummy(warn_dummy)
    );

    function automatic logic [31:0] actual_vec();
        return {res_cmd, res_addr, res_bank, res_bank_known, res_data, res_len,
                warn_opcode, warn_header, warn_length, warn_bank, warn_dummy};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input int n, input logic [7:0] m0, input logic [7:0] m1,
                        input logic [7:0] m2, input logic [7:0] s1, input logic [7:0] s2,
                        input string req);
        logic [2:0] op;
        logic [4:0] addr;
        logic [7:0] len;
        logic [7:0] dat;
        logic       ok, known, mac;
        logic       wo, wh, wl, wb, wd;
        op    = m0[7:5];
        addr  = m0[4:0];
        len   = (n > 255) ? 8'd255 : n[7:0];
        known = &mk;
        mac   = mac_lookup(mb, addr);
        wo = 0; wh = 0; wl = 0; wb = 0; wd = 0;
        case (op)
            3'd0:             ok = (len == 2) || (len == 3);
            3'd2, 3'd4, 3'd5: ok = (len == 2);
            3'd7:             ok = (len == 1);
            3'd1, 3'd3:       ok = 1'b1;
            default:          ok = 1'b0;
        endcase
        if (op == 3'd6) begin
            wo = 1;
        end else begin
            wl = !ok;
            if (op == 3'd1) wh = (m0 != 8'h3A);
            if (op == 3'd3) wh = (m0 != 8'h7A);
            if (ok && (op == 3'd0 || op == 3'd2 || op == 3'd4 || op == 3'd5)) begin
                wb = !known;
                if (op == 3'd0 && known) wd = mac ? (len != 3) : (len != 2);
            end
        end
        case (op)
            3'd0:                   dat = (len == 3) ? s2 : ((n >= 2) ? s1 : 8'h00);
            3'd1:                   dat = (n >= 2) ? s1 : 8'h00;
            3'd2, 3'd3, 3'd4, 3'd5: dat = (n >= 2) ? m1 : 8'h00;
            default:                dat = 8'h00;
        endcase
        if (n > 0) begin
            q_vec.push_back({op, addr, mb, known, dat, len, wo, wh, wl, wb, wd});
            q_req.push_back(req);
            npush++;
        end
        if (ok && op != 3'd6) begin
            if (op == 3'd2 && addr == 5'h1F) begin mb = m1[1:0]; mk = 2'b11; end
            if ((op == 3'd4 || op == 3'd5) && addr == 5'h1F) begin
                for (int i = 0; i < 2; i++) begin
                    if (m1[i]) begin mb[i] = (op == 3'd4); mk[i] = 1'b1; end
                end
            end
            if (op == 3'd7) begin mb = 2'b00; mk = 2'b11; end
        end
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld  = 1'b1;
            mosi_byte = (i == 0) ? m0 : (i == 1) ? m1 : (i == 2) ? m2 : 8'h55;
            miso_byte = (i == 0) ? 8'hEE : (i == 1) ? s1 : (i == 2) ? s2 : 8'hAA;
        end
        @(negedge clk);
        byte_vld = 1'b0;
        if (n == 0) begin
            repeat (3) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && done) begin
            ndone++;
            if (q_vec.size() == 0) begin
                chk(1'b0, "R3 unexpected done", actual_vec(), 32'h0);
            end else begin
                logic [31:0] e;
                string       r;
                e = q_vec.pop_front();
                r = q_req.pop_front();
                chk(actual_vec() == e, r, actual_vec(), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && actual_vec() == 32'h0, "R1 reset state", {31'h0, done} ^ actual_vec(), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && actual_vec() == 32'h0, "R1 after reset", actual_vec(), 32'h0);

        send(2, 8'h05, 8'h00, 8'h00, 8'h3C, 8'h00, "R10 read with bank unknown");
        held = actual_vec();
        send(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3 empty frame");
        chk(actual_vec() == held, "R3 results held over empty frame", actual_vec(), held);
        send(2, 8'h9F, 8'h01, 8'h00, 8'h00, 8'h00, "R8 bit set bank bit0");
        send(2, 8'h03, 8'h00, 8'h00, 8'h11, 8'h00, "R8 half known still warns");
        send(2, 8'hBF, 8'h02, 8'h00, 8'h00, 8'h00, "R8 bit clear bank bit1");
        send(2, 8'h03, 8'h00, 8'h00, 8'h22, 8'h00, "R11 plain read bank1");
        send(2, 8'h5F, 8'h02, 8'h00, 8'h00, 8'h00, "R7 write bank reg");
        send(3, 8'h04, 8'h00, 8'h00, 8'h77, 8'h99, "R12 mac read with dummy byte");
        send(2, 8'h04, 8'h00, 8'h00, 8'h66, 8'h00, "R11 mac read without dummy");
        send(3, 8'h1C, 8'h00, 8'h00, 8'h44, 8'h88, "R11 plain read with dummy");
        send(2, 8'hC5, 8'h03, 8'h00, 8'h00, 8'h00, "R4 undefined opcode");
        send(4, 8'h3A, 8'h00, 8'h00, 8'h5A, 8'h6B, "R12 buffer read");
        send(2, 8'h3B, 8'h00, 8'h00, 8'h5A, 8'h00, "R5 bad buffer read header");
        send(2, 8'h7A, 8'hD2, 8'h00, 8'h00, 8'h00, "R5 buffer write");
        send(2, 8'h7B, 8'hD2, 8'h00, 8'h00, 8'h00, "R5 bad buffer write header");
        send(3, 8'h5F, 8'h01, 8'h01, 8'h00, 8'h00, "R6 long bank write");
        send(2, 8'h04, 8'h00, 8'h00, 8'h12, 8'h00, "R6 bank unchanged after bad length");
        send(2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, "R6 long soft reset");
        send(1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, "R9 soft reset");
        send(2, 8'h08, 8'h00, 8'h00, 8'h31, 8'h00, "R9 read after reset");
        send(2, 8'h9F, 8'h03, 8'h00, 8'h00, 8'h00, "R8 bit set both bits");
        send(300, 8'h7A, 8'h0F, 8'h00, 8'h00, 8'h00, "R13 saturating length");
        send(1, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, "R6 short control read");
        send(2, 8'hA1, 8'hFF, 8'h00, 8'h00, 8'h00, "R2 bit clear other address");

        repeat (4) @(negedge clk);
        chk(ndone == npush && q_vec.size() == 0, "R3 done count",
            32'(ndone), 32'(npush));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule